// File: doc/BRIEF.md
# Per-Channel Sample Rate Converter with Linear Blend

This block is the rate-conversion datapath of one audio voice. A free-running divider turns a 27 MHz clock-enable strobe into an update tick of 281.25 kHz (one tick per 96 strobes). On each tick, while the voice runs, a 19-bit phase step is added to a 19-bit accumulator. When that addition carries out of bit 18, the block shifts its two-entry sample history and raises a fetch request for the following sample. The sample source answers with a 16-bit unsigned word and a valid strobe.

The output is a registered 16-bit unsigned sample. It is either the newest stored sample, or a linear blend in which the older sample is weighted by 0x80000 minus the accumulator and the newer sample by the accumulator. The step for a wanted playback rate is rate × 0x80000 / 281250. An initialisation pulse clears the accumulator. It also fills the history with a mid-scale word, so that the first blended outputs sit at the signal's centre line. That word is 0x8000 for wide data and 0x8080 for byte-packed data.

Top module: `resample_phase_core`

## Requirements
- R1: While reset is low, and until the first update after it is released, `fetch_req_o` is 0 and `sample_o` is 0x0000. The accumulator and both history entries start at 0.
- R2: The update tick occurs on every 96th cycle with `clk27_en` high, counted from reset. On a tick with `ch_run` high, the accumulator becomes (accumulator + `step_i`) mod 2^19. Without a tick it holds.
- R3: A wrap is a tick with `ch_run` high whose addition carries out of bit 18. On a wrap, the newer history entry moves into the older one, the buffered fetched sample becomes the newer entry, and `fetch_req_o` is 1 from the next cycle.
- R4: `fetch_req_o` stays 1 until a cycle with `smp_valid_i` high. At that clock edge, `smp_i` is stored in the fetch buffer and the request drops, unless a wrap happens in the same edge.
- R5: With `interp_en_i` low, `sample_o` equals the newer history entry as it was one clock earlier.
- R6: With `interp_en_i` high, `sample_o` equals floor(old×(0x80000−acc)/2^19) + floor(new×acc/2^19), limited to 0xFFFF. The operands are the values one clock earlier.
- R7: A cycle with `init_i` high takes priority over all other updates. It clears the accumulator and sets both history entries and the fetch buffer to 0x8000 when `init_wide_i` is 1, or to 0x8080 when it is 0. It also raises `fetch_req_o`.
- R8: If no sample has arrived since the last wrap, the next wrap loads the same buffered sample again as the newer entry.
- R9: `smp_valid_i` in a cycle where `fetch_req_o` is 0 is ignored. The stray word never reaches the output.
- R10: When a wrap and an accepted sample fall in the same edge, the incoming word becomes the newer entry directly and `fetch_req_o` stays 1.
- R11: A blended output is never above the larger of the two entries, and never more than 1 below the smaller one.
- R12: With `ch_run` low, the accumulator and the history hold, and no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk27_en | input | 1 | 27 MHz rate strobe feeding the tick divider |
| ch_run | input | 1 | Voice active; gates accumulation |
| interp_en_i | input | 1 | Select blended output |
| step_i | input | 19 | Phase increment per tick |
| init_i | input | 1 | Initialise accumulator and history |
| init_wide_i | input | 1 | Preset word choice: 1 = 0x8000, 0 = 0x8080 |
| smp_i | input | 16 | Fetched sample word |
| smp_valid_i | input | 1 | `smp_i` carries a sample |
| fetch_req_o | output | 1 | Next sample wanted |
| sample_o | output | 16 | Registered output sample |

## Verification
A wrap and the arrival of a fetched sample can land on the same clock edge. In that case the history shift and the fetch buffer write compete for the newer entry, and the request flag is both set and cleared. The bench provokes this by holding the response back and presenting a valid word in exactly the cycle before a tick that its own phase model predicts will carry. It then judges the result twice: the request must still be raised one cycle later, and the unblended output must show the colliding word one cycle after that. A cycle-accurate reference model also scores every output against the requirements throughout the run.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

  parameter int ACC_W_DEF = 19;
  parameter int SMP_W_DEF = 16;
  parameter int TICK_DIV_DEF = 96;

  // Mid-scale fill word: MSB set; byte-packed data also sets the MSB of
  // the low byte so both packed bytes sit at their own centre line.
  function automatic logic [31:0] mid_fill(input int width, input logic wide);
    logic [31:0] mid;
    mid = 32'd1 << (width - 1);
    if (wide) begin
      return mid;
    end
    return mid | (mid >> 8);
  endfunction

endpackage

// File: rtl/rsmp_tick_div.sv
module rsmp_tick_div #(
  parameter int DIV = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/rsmp_phase_acc.sv
module rsmp_phase_acc #(
  parameter int ACC_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             init,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc,
  output logic             wrap
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;
  logic             adv;

  assign sum = {1'b0, acc_q} + {1'b0, step};
  assign adv = tick && run && !init;

  always_comb begin
    acc_d = acc_q;
    if (init) begin
      acc_d = '0;
    end else if (adv) begin
      acc_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc  = acc_q;
  assign wrap = adv && sum[ACC_W];
endmodule

// File: rtl/rsmp_history.sv
module rsmp_history #(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             init,
  input  logic             init_wide,
  input  logic [SMP_W-1:0] smp,
  input  logic             smp_valid,
  output logic [SMP_W-1:0] newer,
  output logic [SMP_W-1:0] older,
  output logic             fetch_req
);
  import rsmp_pkg::*;

  localparam logic [SMP_W-1:0] FILL_WIDE   = SMP_W'(mid_fill(SMP_W, 1'b1));
  localparam logic [SMP_W-1:0] FILL_NARROW = SMP_W'(mid_fill(SMP_W, 1'b0));

  logic [SMP_W-1:0] new_q, new_d, old_q, old_d, buf_q, buf_d;
  logic             req_q, req_d;
  logic             accept;
  logic [SMP_W-1:0] fill;

  assign accept = smp_valid && req_q;
  assign fill   = init_wide ? FILL_WIDE : FILL_NARROW;

  always_comb begin
    new_d = new_q;
    old_d = old_q;
    buf_d = buf_q;
    req_d = req_q;
    if (init) begin
      new_d = fill;
      old_d = fill;
      buf_d = fill;
      req_d = 1'b1;
    end else begin
      if (accept) begin
        buf_d = smp;
        req_d = 1'b0;
      end
      if (wrap) begin
        old_d = new_q;
        new_d = accept ? smp : buf_q;
        req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q <= '0;
      old_q <= '0;
      buf_q <= '0;
      req_q <= 1'b0;
    end else begin
      new_q <= new_d;
      old_q <= old_d;
      buf_q <= buf_d;
      req_q <= req_d;
    end
  end

  assign newer     = new_q;
  assign older     = old_q;
  assign fetch_req = req_q;
endmodule

// File: rtl/rsmp_blend.sv
module rsmp_blend #(
  parameter int ACC_W = 19,
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             interp_en,
  input  logic [ACC_W-1:0] acc,
  input  logic [SMP_W-1:0] newer,
  input  logic [SMP_W-1:0] older,
  output logic [SMP_W-1:0] sample
);
  localparam int WGT_W = ACC_W + 1;
  localparam int P0_W  = SMP_W + WGT_W;
  localparam int P1_W  = SMP_W + ACC_W;
  localparam int SUM_W = SMP_W + 2;
  localparam logic [WGT_W-1:0] FULL  = WGT_W'(1) << ACC_W;
  localparam logic [SUM_W-1:0] S_MAX = SUM_W'({SMP_W{1'b1}});

  logic [WGT_W-1:0] w_old;
  logic [P0_W-1:0]  p_old;
  logic [P1_W-1:0]  p_new;
  logic [SUM_W-1:0] total;
  logic [SMP_W-1:0] blended, out_d, out_q;
  logic             unused_frac;

  assign w_old = FULL - {1'b0, acc};
  assign p_old = P0_W'(older) * P0_W'(w_old);
  assign p_new = P1_W'(newer) * P1_W'(acc);
  assign total = SUM_W'(p_old[P0_W-1:ACC_W]) + SUM_W'(p_new[P1_W-1:ACC_W]);
  assign unused_frac = ^{p_old[ACC_W-1:0], p_new[ACC_W-1:0]};

  always_comb begin
    blended = (total > S_MAX) ? {SMP_W{1'b1}} : total[SMP_W-1:0];
    out_d   = interp_en ? blended : newer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

  assign sample = out_q;
endmodule

// File: rtl/resample_phase_core.sv
module resample_phase_core #(
  parameter int ACC_W    = rsmp_pkg::ACC_W_DEF,
  parameter int SMP_W    = rsmp_pkg::SMP_W_DEF,
  parameter int TICK_DIV = rsmp_pkg::TICK_DIV_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk27_en,
  input  logic             ch_run,
  input  logic             interp_en_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic             init_i,
  input  logic             init_wide_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             smp_valid_i,
  output logic             fetch_req_o,
  output logic [SMP_W-1:0] sample_o
);
  logic             rst_meta_q, rst_sync_n;
  logic             tick;
  logic             wrap;
  logic [ACC_W-1:0] acc;
  logic [SMP_W-1:0] newer, older;

  // Reset asserts at once and leaves on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  rsmp_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .en   (clk27_en),
    .tick (tick)
  );

  rsmp_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .tick (tick),
    .run  (ch_run),
    .init (init_i),
    .step (step_i),
    .acc  (acc),
    .wrap (wrap)
  );

  rsmp_history #(.SMP_W(SMP_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wrap     (wrap),
    .init     (init_i),
    .init_wide(init_wide_i),
    .smp      (smp_i),
    .smp_valid(smp_valid_i),
    .newer    (newer),
    .older    (older),
    .fetch_req(fetch_req_o)
  );

  rsmp_blend #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_blend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .interp_en(interp_en_i),
    .acc      (acc),
    .newer    (newer),
    .older    (older),
    .sample   (sample_o)
  );
endmodule

// File: rtl/rsmp_chk.sv
module rsmp_chk #(
  parameter int ACC_W = 19,
  parameter int SMP_W = 16
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             clk27_en,
  input logic             ch_run,
  input logic             interp_en_i,
  input logic             init_i,
  input logic             smp_valid_i,
  input logic             tick,
  input logic             wrap,
  input logic [ACC_W-1:0] acc,
  input logic [SMP_W-1:0] newer,
  input logic [SMP_W-1:0] older,
  input logic             fetch_req_o,
  input logic [SMP_W-1:0] sample_o
);
  logic [SMP_W:0] hi_v, lo_v;
  assign hi_v = (newer > older) ? {1'b0, newer} : {1'b0, older};
  assign lo_v = (newer > older) ? {1'b0, older} : {1'b0, newer};

  // R2
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    tick |-> clk27_en);

  // R3
  wrap_shift_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wrap |=> (fetch_req_o && older == $past(newer)));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (fetch_req_o && !smp_valid_i) |=> fetch_req_o);

  // R9
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!fetch_req_o && !wrap && !init_i) |=> !fetch_req_o);

  // R5
  direct_out_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !interp_en_i |=> sample_o == $past(newer));

  // R11
  blend_upper_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    interp_en_i |=> {1'b0, sample_o} <= $past(hi_v));

  // R11
  blend_lower_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    interp_en_i |=> ({1'b0, sample_o} + 1'b1) >= $past(lo_v));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ch_run && !init_i) |=> ($stable(acc) && $stable(newer) && $stable(older)));
endmodule

bind resample_phase_core rsmp_chk #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .clk27_en   (clk27_en),
  .ch_run     (ch_run),
  .interp_en_i(interp_en_i),
  .init_i     (init_i),
  .smp_valid_i(smp_valid_i),
  .tick       (tick),
  .wrap       (wrap),
  .acc        (acc),
  .newer      (newer),
  .older      (older),
  .fetch_req_o(fetch_req_o),
  .sample_o   (sample_o)
);

// File: tb/tb_resample_phase_core.sv
module tb_resample_phase_core;
  localparam int DIV = 96;
  localparam int FULL = 524288;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk27_en = 1'b0;
  logic        ch_run = 1'b0;
  logic        interp_en_i = 1'b0;
  logic [18:0] step_i = '0;
  logic        init_i = 1'b0;
  logic        init_wide_i = 1'b0;
  logic [15:0] smp_i = '0;
  logic        smp_valid_i = 1'b0;
  logic        fetch_req_o;
  logic [15:0] sample_o;

  resample_phase_core dut (
    .clk(clk), .rst_n(rst_n), .clk27_en(clk27_en), .ch_run(ch_run),
    .interp_en_i(interp_en_i), .step_i(step_i), .init_i(init_i),
    .init_wide_i(init_wide_i), .smp_i(smp_i), .smp_valid_i(smp_valid_i),
    .fetch_req_o(fetch_req_o), .sample_o(sample_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R1";
  logic  resp_on = 1'b0;
  logic [15:0] resp_data = 16'h1357;

  // Reference model state, updated from the requirements.
  int m_cnt, m_acc, m_new, m_old, m_buf, m_out;
  logic m_req;
  logic [1:0] m_rq;
  int exp_out_q[$];
  logic exp_req_q[$];

  function automatic int blend(int o, int n, int a);
    longint t;
    t = ((longint'(o) * longint'(FULL - a)) >>> 19) + ((longint'(n) * longint'(a)) >>> 19);
    if (t > 65535) t = 65535;
    return int'(t);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Driver side of the scoreboard: the model pushes each expected result.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rq = 2'b00; m_cnt = 0; m_acc = 0; m_new = 0; m_old = 0;
      m_buf = 0; m_req = 1'b0; m_out = 0;
    end else begin
      cyc++;
      if (m_rq[1]) begin
        int  eo;
        logic tk, wr, acc_ok;
        int  s;
        eo = interp_en_i ? blend(m_old, m_new, m_acc) : m_new;
        tk = clk27_en && (m_cnt == DIV - 1);
        if (clk27_en) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
        s = m_acc + int'(step_i);
        wr = tk && ch_run && (s >= FULL) && !init_i;
        acc_ok = smp_valid_i && m_req;
        if (init_i) begin
          m_acc = 0;
          m_new = init_wide_i ? 32'h8000 : 32'h8080;
          m_old = m_new; m_buf = m_new; m_req = 1'b1;
        end else begin
          if (tk && ch_run) m_acc = s % FULL;
          if (wr) begin
            m_old = m_new;
            m_new = acc_ok ? int'(smp_i) : m_buf;
          end
          if (acc_ok) begin m_buf = int'(smp_i); m_req = 1'b0; end
          if (wr) m_req = 1'b1;
        end
        exp_out_q.push_back(eo);
        exp_req_q.push_back(m_req);
      end
      m_rq = {m_rq[0], 1'b1};
    end
  end

  // Monitor side: compare away from the active edge.
  always @(negedge clk) begin
    while (exp_out_q.size() > 0) begin
      int eo;
      logic er;
      eo = exp_out_q.pop_front();
      er = exp_req_q.pop_front();
      check({tag, " sample_o"}, int'(sample_o), eo);
      check({tag, " fetch_req_o"}, int'(fetch_req_o), int'(er));
    end
  end

  // Sample source answering each request one cycle later.
  always @(negedge clk) begin
    if (resp_on) begin
      if (smp_valid_i) resp_data = resp_data * 16'd25173 + 16'd13849;
      smp_valid_i = fetch_req_o;
      smp_i = resp_data;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic pulse_init(logic wide);
    @(negedge clk); init_wide_i = wide; init_i = 1'b1;
    @(negedge clk); init_i = 1'b0;
  endtask

  initial begin
    int t1, t2, hold_val, guard;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 sample_o", int'(sample_o), 0);
    check("R1 fetch_req_o", int'(fetch_req_o), 0);
    rst_n = 1'b1;
    clk27_en = 1'b1;
    @(negedge clk);
    check("R1 sample_o after release", int'(sample_o), 0);
    repeat (3) @(negedge clk);

    // R7: narrow preset
    tag = "R7";
    pulse_init(1'b0);
    @(negedge clk);
    check("R7 narrow fill", int'(sample_o), 16'h8080);
    check("R7 request raised", int'(fetch_req_o), 1);

    // R2 R3 R4 R5: periodic wraps with a prompt source
    tag = "R2 R3 R4 R5";
    resp_on = 1'b1; step_i = 19'h40000; ch_run = 1'b1;
    repeat (10) @(negedge clk);
    while (fetch_req_o) @(negedge clk);
    while (!fetch_req_o) @(negedge clk);
    t1 = cyc;
    while (fetch_req_o) @(negedge clk);
    while (!fetch_req_o) @(negedge clk);
    t2 = cyc;
    check("R2 wrap period for half step", t2 - t1, 2 * DIV);
    repeat (1500) @(negedge clk);

    // R6 R11: blended output across two step values
    tag = "R6 R11";
    interp_en_i = 1'b1; step_i = 19'h01234;
    repeat (8000) @(negedge clk);
    step_i = 19'h2A3C5;
    repeat (6000) @(negedge clk);

    // R8 R4: source stops answering, wraps reuse the buffered word
    tag = "R8 R4";
    @(negedge clk); resp_on = 1'b0; smp_valid_i = 1'b0;
    interp_en_i = 1'b0; step_i = 19'h7FFFF;
    while (!fetch_req_o) @(negedge clk);
    repeat (3) @(negedge clk);
    hold_val = int'(sample_o);
    repeat (4 * DIV) @(negedge clk);
    check("R8 output after missed fetches", int'(sample_o), hold_val);
    check("R4 request still raised", int'(fetch_req_o), 1);

    // R9: stray words while no request is outstanding
    tag = "R9";
    resp_on = 1'b1;
    while (fetch_req_o) @(negedge clk);
    resp_on = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      smp_valid_i = !fetch_req_o; smp_i = 16'h1234;
      @(negedge clk);
    end
    smp_valid_i = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    checks++;
    if (sample_o == 16'h1234) begin
      errors++;
      $display("FAIL R9: actual %0h expected not 1234", sample_o);
    end

    // R12: voice stopped
    tag = "R12";
    resp_on = 1'b1; ch_run = 1'b0;
    repeat (20) @(negedge clk);
    hold_val = int'(sample_o);
    repeat (3 * DIV) @(negedge clk);
    check("R12 output held", int'(sample_o), hold_val);
    check("R12 no request", int'(fetch_req_o), 0);

    // R7 wide preset, then R10 collision
    tag = "R7";
    resp_on = 1'b0; smp_valid_i = 1'b0;
    pulse_init(1'b1);
    @(negedge clk);
    check("R7 wide fill", int'(sample_o), 16'h8000);
    tag = "R10";
    ch_run = 1'b1; step_i = 19'h7FFFF;
    guard = 0;
    while (!(fetch_req_o && m_cnt == DIV - 1 && (m_acc + int'(step_i)) >= FULL)
           && guard < 2000) begin
      @(negedge clk); guard++;
    end
    check("R10 collision setup reached", int'(guard < 2000), 1);
    smp_valid_i = 1'b1; smp_i = 16'hBEEF;
    @(negedge clk);
    smp_valid_i = 1'b0;
    check("R10 request stays raised", int'(fetch_req_o), 1);
    @(negedge clk);
    check("R10 incoming word taken directly", int'(sample_o), 16'hBEEF);
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule